// File: doc/BRIEF.md
# Bank-Switched Memory Chip-Select Decoder

This block sits on a memory card with eight byte-wide sockets. It turns the upper bits of a 16-bit bus address into eight active-low socket chip selects. A socket is selected only when the address falls in its window, when the current bank number matches the bank that the strapped board identity assigns to that socket, when the memory-expansion line agrees with the strapped qualification mode, and when the socket is enabled. The bank number itself comes from an external bank register, which is not part of this block.

Three socket layouts are strapped. Layout 0 uses 8K devices as a single 64K block. Layout 1 uses 8K devices as two 32K half-banks that overlap in one 32K window. Layout 2 uses 32K devices, and each socket pair forms its own 64K bank. Per-pair write inhibits let protected RAM act like ROM: the chip select still fires, but the gated write strobe is withheld. A board-selected flag tells the card when to drive the data bus. All outputs are combinational.

Top module: `bank_chip_select`

## Requirements
- R1: While `mem_req` is low, every `cs_n` bit is 1 and both `board_sel` and `wr_gated` are 0, whatever the other inputs are.
- R2: With `layout` = 0, socket `addr_hi` (the upper three address bits) is selected, but only when the effective bank equals all six bits of `bank_id`.
- R3: With `layout` = 1 and n = `bank_id[4:0]`, sockets 4 to 7 answer to bank 2n and sockets 0 to 3 answer to bank 2n+1. Within its group, the socket index is `{addr_hi[1:0]}`.
- R4: With `layout` = 1, a socket can be selected only when `addr_hi[2]` equals `map_hi`. `map_hi` = 0 places the window at 0000-7FFF and `map_hi` = 1 places it at 8000-FFFF.
- R5: With `layout` = 2 and m = `bank_id[3:0]`, socket pair k (sockets 2k and 2k+1) answers to bank 4m+k. The even socket covers `addr_hi[2]` = 0 and the odd socket covers `addr_hi[2]` = 1.
- R6: With `layout` = 3, no socket is ever selected.
- R7: `memex_mode` 1 selects only while `memex` is 1, `memex_mode` 2 selects only while `memex` is 0, and modes 0 and 3 ignore `memex`.
- R8: A socket whose `sock_en` bit is 0 never asserts its chip select.
- R9: While `wr_inhibit[p]` is 1, an access to socket 2p or 2p+1 still asserts that chip select, but `wr_gated` stays 0.
- R10: `wr_gated` is 1 exactly when `wr_strobe` is 1 and a selected socket's pair is not inhibited. `board_sel` is 1 exactly when some chip select is asserted.
- R11: When `bank_sel_en` is 0, the effective bank is 0 whatever `bank_val` holds. When it is 1, the effective bank is `bank_val`.
- R12: At most one chip select is asserted at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_hi | input | 3 | Upper three bits of the 16-bit memory address |
| mem_req | input | 1 | Memory request active, high |
| wr_strobe | input | 1 | Bus write strobe, high |
| memex | input | 1 | Memory-expansion line from the bus |
| bank_val | input | 6 | Current bank number from the bank register |
| bank_sel_en | input | 1 | Strap: bank comparison uses `bank_val` (1) or bank 0 (0) |
| layout | input | 2 | Strap: socket layout code 0..3 |
| map_hi | input | 1 | Strap: 32K window placement in layout 1 |
| bank_id | input | 6 | Strap: board bank identity |
| memex_mode | input | 2 | Strap: memory-expansion qualification mode |
| sock_en | input | 8 | Strap: per-socket enable |
| wr_inhibit | input | 4 | Per-pair write inhibit switches |
| cs_n | output | 8 | Active-low socket chip selects |
| wr_gated | output | 1 | Write strobe passed to the selected socket |
| board_sel | output | 1 | Some socket on this board is selected |

## Verification
On every input change, the assertions check the cycle-independent rules: quiet outputs with no request, at most one select, silence of disabled sockets, blocking by the expansion line and by the unused layout code, and a write strobe that reaches only an uninhibited selected pair. Which socket answers to which bank, with each layout, window placement and forced-bank setting, is a mapping that only the bench's reference model can judge. The bench checks it with directed cases at the bank and window edges and with a long run of random vectors.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    LAY_FLAT64  = 2'd0,
    LAY_HALF32  = 2'd1,
    LAY_WIDE32K = 2'd2,
    LAY_NONE    = 2'd3
  } layout_e;

  typedef enum logic [1:0] {
    MX_ANY  = 2'd0,
    MX_HIGH = 2'd1,
    MX_LOW  = 2'd2,
    MX_ANY2 = 2'd3
  } mx_mode_e;

  function automatic logic memex_pass(input logic [1:0] mode, input logic mx);
    case (mx_mode_e'(mode))
      MX_HIGH: memex_pass = mx;
      MX_LOW:  memex_pass = ~mx;
      default: memex_pass = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/bcs_socket_match.sv
module bcs_socket_match #(
  parameter int SEL_W  = 3,
  parameter int BANK_W = 6,
  parameter int IDX    = 0
) (
  input  logic [SEL_W-1:0]  addr_hi,
  input  logic [1:0]        layout,
  input  logic              map_hi,
  input  logic [BANK_W-1:0] bank_id,
  input  logic [BANK_W-1:0] eff_bank,
  output logic              win_hit,
  output logic              bank_hit
);
  import bcs_pkg::*;

  localparam logic [SEL_W-1:0] IDX_V = SEL_W'(IDX);

  function automatic logic [BANK_W-1:0] target_bank(input logic [1:0] lay,
                                                    input logic [BANK_W-1:0] id);
    case (layout_e'(lay))
      LAY_FLAT64:  target_bank = id;
      LAY_HALF32:  target_bank = {id[BANK_W-2:0], ~IDX_V[SEL_W-1]};
      LAY_WIDE32K: target_bank = {id[BANK_W-3:0], IDX_V[SEL_W-1:1]};
      default:     target_bank = '0;
    endcase
  endfunction

  function automatic logic in_window(input logic [1:0] lay, input logic mh,
                                     input logic [SEL_W-1:0] a);
    case (layout_e'(lay))
      LAY_FLAT64:  in_window = (a == IDX_V);
      LAY_HALF32:  in_window = (a[SEL_W-1] == mh) && (a[SEL_W-2:0] == IDX_V[SEL_W-2:0]);
      LAY_WIDE32K: in_window = (a[SEL_W-1] == IDX_V[0]);
      default:     in_window = 1'b0;
    endcase
  endfunction

  assign win_hit  = in_window(layout, map_hi, addr_hi);
  assign bank_hit = (eff_bank == target_bank(layout, bank_id));
endmodule

// File: rtl/bcs_write_gate.sv
module bcs_write_gate #(
  parameter int SOCK_N = 8
) (
  input  logic [SOCK_N-1:0]   cs_act,
  input  logic [SOCK_N/2-1:0] wr_inhibit,
  input  logic                wr_strobe,
  output logic [SOCK_N-1:0]   sock_locked,
  output logic                wr_gated
);
  localparam int PAIR_N = SOCK_N / 2;

  for (genvar p = 0; p < PAIR_N; p++) begin : g_pair
    assign sock_locked[2*p]   = wr_inhibit[p];
    assign sock_locked[2*p+1] = wr_inhibit[p];
  end

  assign wr_gated = wr_strobe && |(cs_act & ~sock_locked);
endmodule

// File: rtl/bank_chip_select.sv
module bank_chip_select #(
  parameter int SOCK_N = 8,
  parameter int BANK_W = 6
) (
  input  logic [2:0]          addr_hi,
  input  logic                mem_req,
  input  logic                wr_strobe,
  input  logic                memex,
  input  logic [BANK_W-1:0]   bank_val,
  input  logic                bank_sel_en,
  input  logic [1:0]          layout,
  input  logic                map_hi,
  input  logic [BANK_W-1:0]   bank_id,
  input  logic [1:0]          memex_mode,
  input  logic [SOCK_N-1:0]   sock_en,
  input  logic [SOCK_N/2-1:0] wr_inhibit,
  output logic [SOCK_N-1:0]   cs_n,
  output logic                wr_gated,
  output logic                board_sel
);
  import bcs_pkg::*;

  localparam int SEL_W = $clog2(SOCK_N);

  logic [BANK_W-1:0] eff_bank;
  logic              mx_ok;
  logic [SOCK_N-1:0] win_hit;
  logic [SOCK_N-1:0] bank_hit;
  logic [SOCK_N-1:0] cs_act;
  logic [SOCK_N-1:0] sock_locked;

  assign eff_bank = bank_sel_en ? bank_val : '0;
  assign mx_ok    = memex_pass(memex_mode, memex);

  for (genvar s = 0; s < SOCK_N; s++) begin : g_sock
    bcs_socket_match #(.SEL_W(SEL_W), .BANK_W(BANK_W), .IDX(s)) u_match (
      .addr_hi  (addr_hi),
      .layout   (layout),
      .map_hi   (map_hi),
      .bank_id  (bank_id),
      .eff_bank (eff_bank),
      .win_hit  (win_hit[s]),
      .bank_hit (bank_hit[s])
    );
    assign cs_act[s] = mem_req && mx_ok && sock_en[s] && win_hit[s] && bank_hit[s];
  end

  bcs_write_gate #(.SOCK_N(SOCK_N)) u_wgate (
    .cs_act      (cs_act),
    .wr_inhibit  (wr_inhibit),
    .wr_strobe   (wr_strobe),
    .sock_locked (sock_locked),
    .wr_gated    (wr_gated)
  );

  assign cs_n      = ~cs_act;
  assign board_sel = |cs_act;
endmodule

// File: rtl/bank_chip_select_chk.sv
module bank_chip_select_chk #(
  parameter int SOCK_N = 8
) (
  input logic                mem_req,
  input logic                memex,
  input logic [1:0]          memex_mode,
  input logic [1:0]          layout,
  input logic [SOCK_N-1:0]   sock_en,
  input logic                wr_strobe,
  input logic [SOCK_N/2-1:0] wr_inhibit,
  input logic [SOCK_N-1:0]   cs_n,
  input logic                wr_gated,
  input logic                board_sel
);
  localparam int PAIR_N = SOCK_N / 2;

  logic [SOCK_N-1:0] sel;
  assign sel = ~cs_n;

  always_comb begin
    // R1
    idle_quiet_chk: assert (mem_req || (sel == '0 && !board_sel && !wr_gated))
      else $error("idle outputs active");
    // R12
    single_cs_chk: assert ($onehot0(sel))
      else $error("several chip selects");
    // R8
    disabled_quiet_chk: assert ((sel & ~sock_en) == '0)
      else $error("disabled socket selected");
    // R7
    memex_block_chk: assert (!((memex_mode == 2'd1 && !memex) || (memex_mode == 2'd2 && memex)) || sel == '0)
      else $error("expansion line not honoured");
    // R6
    no_layout_chk: assert (layout != 2'd3 || sel == '0)
      else $error("unused layout selected");
    // R10
    wr_source_chk: assert (!wr_gated || (wr_strobe && board_sel))
      else $error("write without strobe or select");
    for (int p = 0; p < PAIR_N; p++) begin
      // R9
      inhibit_pair_chk: assert (!(wr_inhibit[p] && sel[2*p+:2] != 2'b00) || !wr_gated)
        else $error("write reached inhibited pair");
    end
  end
endmodule

bind bank_chip_select bank_chip_select_chk #(.SOCK_N(SOCK_N)) u_chk (
  .mem_req    (mem_req),
  .memex      (memex),
  .memex_mode (memex_mode),
  .layout     (layout),
  .sock_en    (sock_en),
  .wr_strobe  (wr_strobe),
  .wr_inhibit (wr_inhibit),
  .cs_n       (cs_n),
  .wr_gated   (wr_gated),
  .board_sel  (board_sel)
);

// File: tb/bank_chip_select_bench.sv
module bank_chip_select_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] addr;
  logic        mem_req, wr_strobe, memex, bank_sel_en, map_hi;
  logic [5:0]  bank_val, bank_id;
  logic [1:0]  layout, memex_mode;
  logic [7:0]  sock_en;
  logic [3:0]  wr_inhibit;
  logic [7:0]  cs_n;
  logic        wr_gated, board_sel;

  int checks = 0;
  int failures = 0;

  bank_chip_select u_bank_chip_select (
    .addr_hi(addr[15:13]), .mem_req(mem_req), .wr_strobe(wr_strobe), .memex(memex),
    .bank_val(bank_val), .bank_sel_en(bank_sel_en), .layout(layout), .map_hi(map_hi),
    .bank_id(bank_id), .memex_mode(memex_mode), .sock_en(sock_en), .wr_inhibit(wr_inhibit),
    .cs_n(cs_n), .wr_gated(wr_gated), .board_sel(board_sel)
  );

  // Behavioural reference: each socket owns an address range and a bank number.
  task automatic model(output logic [7:0] ecs_n, output logic ebs, output logic ewr);
    int eff, base, size, tbank;
    bit mx_ok;
    ecs_n = 8'hFF; ebs = 0; ewr = 0;
    eff = bank_sel_en ? int'(bank_val) : 0;
    mx_ok = (memex_mode == 1) ? memex : (memex_mode == 2) ? !memex : 1'b1;
    for (int s = 0; s < 8; s++) begin
      bit hit;
      base = 0; size = 0; tbank = -1;
      if (layout == 0) begin
        base = s * 8192; size = 8192; tbank = int'(bank_id);
      end else if (layout == 1) begin
        base = (map_hi ? 32768 : 0) + (s % 4) * 8192; size = 8192;
        tbank = int'(bank_id % 32) * 2 + ((s < 4) ? 1 : 0);
      end else if (layout == 2) begin
        base = (s % 2) * 32768; size = 32768;
        tbank = int'(bank_id % 16) * 4 + s / 2;
      end
      hit = mem_req && mx_ok && sock_en[s] && size > 0 && int'(addr) >= base &&
            int'(addr) < base + size && eff == tbank;
      if (hit) begin
        ecs_n[s] = 1'b0;
        ebs = 1'b1;
        if (wr_strobe && !wr_inhibit[s/2]) ewr = 1'b1;
      end
    end
  endtask

  task automatic check(input string tag);
    logic [7:0] ecs;
    logic ebs, ewr;
    @(negedge clk);
    model(ecs, ebs, ewr);
    checks++;
    if (cs_n !== ecs || board_sel !== ebs || wr_gated !== ewr) begin
      failures++;
      $display("FAIL %s: cs_n=%h bs=%b wr=%b expected cs_n=%h bs=%b wr=%b",
               tag, cs_n, board_sel, wr_gated, ecs, ebs, ewr);
    end
    @(posedge clk);
  endtask

  task automatic base_cfg();
    mem_req = 1; wr_strobe = 0; memex = 0; bank_sel_en = 1; map_hi = 0;
    bank_val = 0; bank_id = 0; layout = 0; memex_mode = 0;
    sock_en = 8'hFF; wr_inhibit = 0; addr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    base_cfg();
    mem_req = 0; wr_strobe = 1;
    @(posedge clk);
    check("R1 idle with write strobe");
    if (cs_n !== 8'hFF) begin failures++; $display("FAIL R1 cs_n=%h expected ff", cs_n); end
    checks++;

    // R2 flat 64K block, bank 5
    base_cfg(); bank_id = 6'd5; bank_val = 6'd5;
    for (int s = 0; s < 8; s++) begin
      addr = 16'(s * 8192 + 8191);
      check("R2 flat socket window");
    end
    bank_val = 6'd6; addr = 16'h4000; check("R2 flat bank mismatch");

    // R3 R4 half banks, n=3
    base_cfg(); layout = 1; bank_id = 6'd3; map_hi = 1;
    bank_val = 6'd6; addr = 16'h8000; check("R3 sockets 4-7 even bank");
    addr = 16'hE123; check("R3 even bank top socket");
    bank_val = 6'd7; addr = 16'hA000; check("R3 sockets 0-3 odd bank");
    bank_val = 6'd8; check("R3 bank outside pair");
    bank_val = 6'd7; addr = 16'h2000; check("R4 window at upper half only");
    map_hi = 0; addr = 16'h2000; check("R4 lower window");
    addr = 16'hA000; check("R4 upper address with lower map");

    // R5 wide 32K sockets, m=2 -> banks 8..11
    base_cfg(); layout = 2; bank_id = 6'd2;
    bank_val = 6'd9; addr = 16'h1234; check("R5 pair 1 even socket");
    addr = 16'h9000; check("R5 pair 1 odd socket");
    bank_val = 6'd11; addr = 16'hFFFF; check("R5 pair 3 odd socket");
    bank_val = 6'd12; check("R5 next bank belongs elsewhere");

    // R6
    base_cfg(); layout = 3; addr = 16'h0000; check("R6 unused layout");

    // R7
    base_cfg();
    for (int m = 0; m < 4; m++) begin
      for (int x = 0; x < 2; x++) begin
        memex_mode = 2'(m); memex = x[0]; addr = 16'h6000;
        check("R7 expansion qualification");
      end
    end

    // R8
    base_cfg(); sock_en = 8'b1111_0111; addr = 16'h6000; check("R8 disabled socket 3");
    addr = 16'h8000; check("R8 enabled neighbour");

    // R9 R10
    base_cfg(); layout = 2; wr_strobe = 1; wr_inhibit = 4'b0010;
    bank_val = 6'd1; addr = 16'h0100; check("R9 write to inhibited socket 2");
    wr_strobe = 0; check("R9 read of inhibited socket 2");
    wr_strobe = 1; bank_val = 6'd0; check("R10 write to open pair 0");
    mem_req = 0; check("R1 write strobe with no request");

    // R11
    base_cfg(); bank_sel_en = 0; bank_val = 6'd9; bank_id = 6'd0; addr = 16'hC000;
    check("R11 forced bank zero matches");
    bank_id = 6'd9; check("R11 forced bank ignores bank_val");

    // R12 and all rules under random vectors
    for (int i = 0; i < 3000; i++) begin
      addr = 16'($urandom); mem_req = ($urandom % 8) != 0; wr_strobe = 1'($urandom);
      memex = 1'($urandom); bank_sel_en = ($urandom % 4) != 0; map_hi = 1'($urandom);
      layout = 2'($urandom); memex_mode = 2'($urandom);
      bank_id = 6'($urandom); sock_en = 8'($urandom) | 8'($urandom);
      wr_inhibit = 4'($urandom) & 4'($urandom);
      bank_val = ($urandom % 2 == 0) ? bank_id : 6'($urandom);
      if (layout == 1 && $urandom % 2 == 0) bank_val = {bank_id[4:0], 1'($urandom)};
      if (layout == 2 && $urandom % 2 == 0) bank_val = {bank_id[3:0], 2'($urandom)};
      check("R12 random vector");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule